// File: doc/BRIEF.md
# Counter Snapshot Capture Control Register

This block is a 64-bit control and status register through which software asks a bank of performance counters to take a snapshot, then polls until the snapshot is finished. One bit serves as both trigger and status. Writing a one to it starts a capture. Writing a zero to it does nothing. While the capture is running, the same bit reads back as one.

A second bit reports the outcome. It reads one while no valid snapshot exists, and zero once the counter bank reports that the counters were captured. The block sends the counter bank a one-cycle request pulse. It then waits, for as many cycles as the bank needs, until a completion strobe arrives together with a success flag.

The counter bank and its shadow storage are outside this block. Software drives a plain write port. The read port always presents the current register value.

Top module: `snap_ctl_reg`

## Requirements
- R1: Only bit 0 (capture/busy) and bit 32 (no-capture) of `rd_data` can be one. Every other bit reads zero, and writes to those bits have no effect.
- R2: A write with bit 0 set while idle makes bit 0 read 1 from the cycle after the write. With the default `REQ_REGISTERED=1`, it also raises `cap_req` in that cycle.
- R3: A write with bit 0 clear changes neither the register nor `cap_req`, whether the block is idle or busy.
- R4: A `cap_done` strobe while busy makes bit 0 read 0 from the next cycle.
- R5: A write with bit 0 set while busy is ignored. It does not restart the capture, it does not queue a second one, and it raises no `cap_req`.
- R6: `cap_req` is high for exactly one cycle per accepted request.
- R7: From an accepted request until its completion, bit 32 reads 1.
- R8: On completion, bit 32 takes the inverse of `cap_ok`: 0 when captured, 1 when not. A `cap_done` strobe while idle is ignored.
- R9: After reset, bit 0 reads 0, bit 32 reads 1 and `cap_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 64 | Register write data |
| rd_data | output | 64 | Current register value |
| cap_req | output | 1 | One-cycle capture request to the counter bank |
| cap_done | input | 1 | Capture completion strobe from the counter bank |
| cap_ok | input | 1 | With `cap_done`: 1 when the counters were captured |

## Verification
A write or a completion strobe sampled at a rising edge is visible on `rd_data` right after that edge. With the registered variant, the request pulse appears on `cap_req` in that same cycle. The bench therefore drives each stimulus at a falling edge and checks the results at the next falling edge, exactly one register stage later. It then checks again one cycle after that, so that a pulse wider than one cycle is caught. Collisions are applied in single cycles: a write that lands on a busy capture, and a completion strobe that arrives in the same cycle as a write.

// File: rtl/snap_pkg.sv
package snap_pkg;
   typedef enum logic [0:0] {
      CAP_IDLE = 1'b0,
      CAP_BUSY = 1'b1
   } cap_state_t;

   typedef struct packed {
      logic busy;
      logic nocap;
   } snap_status_t;
endpackage

// File: rtl/snap_wr_decode.sv
module snap_wr_decode #(
   parameter int DATA_W   = 64,
   parameter int BUSY_BIT = 0
) (
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              trigger
);
   // Only a one in the trigger bit matters; all other written bits are dropped.
   assign trigger = wr_en & wr_data[BUSY_BIT];
endmodule

// File: rtl/snap_capture_fsm.sv
module snap_capture_fsm
   import snap_pkg::*;
#(
   parameter bit REQ_REGISTERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         trigger,
   input  logic         cap_done,
   input  logic         cap_ok,
   output logic         cap_req,
   output snap_status_t status
);
   cap_state_t state_q, state_d;
   logic       nocap_q, nocap_d;
   logic       start;

   assign start = trigger & (state_q == CAP_IDLE);

   always_comb begin
      state_d = state_q;
      nocap_d = nocap_q;
      unique case (state_q)
         CAP_IDLE: begin
            if (start) begin
               state_d = CAP_BUSY;
               nocap_d = 1'b1;
            end
         end
         CAP_BUSY: begin
            if (cap_done) begin
               state_d = CAP_IDLE;
               nocap_d = ~cap_ok;
            end
         end
         default: state_d = CAP_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= CAP_IDLE;
         nocap_q <= 1'b1;
      end else begin
         state_q <= state_d;
         nocap_q <= nocap_d;
      end
   end

   generate
      if (REQ_REGISTERED) begin : g_req_reg
         logic req_q;
         always_ff @(posedge clk) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= start;
         end
         assign cap_req = req_q;
      end else begin : g_req_comb
         assign cap_req = start;
      end
   endgenerate

   assign status.busy  = (state_q == CAP_BUSY);
   assign status.nocap = nocap_q;
endmodule

// File: rtl/snap_rd_assemble.sv
module snap_rd_assemble
   import snap_pkg::*;
#(
   parameter int DATA_W    = 64,
   parameter int BUSY_BIT  = 0,
   parameter int NOCAP_BIT = 32
) (
   input  snap_status_t      status,
   output logic [DATA_W-1:0] rd_data
);
   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         if (i == BUSY_BIT) begin : g_busy
            assign rd_data[i] = status.busy;
         end else if (i == NOCAP_BIT) begin : g_nocap
            assign rd_data[i] = status.nocap;
         end else begin : g_zero
            assign rd_data[i] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/snap_ctl_reg.sv
module snap_ctl_reg
   import snap_pkg::*;
#(
   parameter int DATA_W         = 64,
   parameter int BUSY_BIT       = 0,
   parameter int NOCAP_BIT      = 32,
   parameter bit REQ_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              cap_req,
   input  logic              cap_done,
   input  logic              cap_ok
);
   localparam int BIT_IDX_W = $clog2(DATA_W);

   initial begin
      assert (DATA_W >= 2) else $fatal(1, "DATA_W too small");
      assert (BUSY_BIT >= 0 && BUSY_BIT < DATA_W) else $fatal(1, "BUSY_BIT out of range");
      assert (NOCAP_BIT >= 0 && NOCAP_BIT < DATA_W) else $fatal(1, "NOCAP_BIT out of range");
      assert (BUSY_BIT != NOCAP_BIT) else $fatal(1, "status bits overlap");
      assert (BIT_IDX_W > 0) else $fatal(1, "bad index width");
   end

   logic         trigger;
   snap_status_t status;

   snap_wr_decode #(
      .DATA_W   (DATA_W),
      .BUSY_BIT (BUSY_BIT)
   ) u_dec (
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .trigger (trigger)
   );

   snap_capture_fsm #(
      .REQ_REGISTERED (REQ_REGISTERED)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .trigger  (trigger),
      .cap_done (cap_done),
      .cap_ok   (cap_ok),
      .cap_req  (cap_req),
      .status   (status)
   );

   snap_rd_assemble #(
      .DATA_W    (DATA_W),
      .BUSY_BIT  (BUSY_BIT),
      .NOCAP_BIT (NOCAP_BIT)
   ) u_rd (
      .status  (status),
      .rd_data (rd_data)
   );
endmodule

// File: rtl/snap_ctl_chk.sv
module snap_ctl_chk #(
   parameter int DATA_W         = 64,
   parameter int BUSY_BIT       = 0,
   parameter int NOCAP_BIT      = 32,
   parameter bit REQ_REGISTERED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              cap_req,
   input logic              cap_done,
   input logic              cap_ok
);
   localparam logic [DATA_W-1:0] LIVE_MASK =
      (DATA_W'(1) << BUSY_BIT) | (DATA_W'(1) << NOCAP_BIT);

   logic busy;
   logic accept;
   assign busy   = rd_data[BUSY_BIT];
   assign accept = !busy && wr_en && wr_data[BUSY_BIT];

   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~LIVE_MASK) == '0);                                         // R1
   AST_ZERO_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[BUSY_BIT] && !cap_done) |=> $stable(rd_data));      // R3
   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cap_done) |=> !rd_data[BUSY_BIT]);                            // R4
   AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !cap_done) |=> (rd_data[BUSY_BIT] && !cap_req));              // R5
   AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      cap_req |=> !cap_req);                                                 // R6
   AST_NOCAP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> rd_data[NOCAP_BIT]);                                          // R7
   AST_NOCAP_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cap_done) |=> (rd_data[NOCAP_BIT] == !$past(cap_ok)));        // R8
   AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cap_done && !accept) |=> $stable(rd_data));                  // R8

   generate
      if (REQ_REGISTERED) begin : g_reg
         AST_REQ_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
            accept |=> (cap_req && rd_data[BUSY_BIT]));                      // R2
      end else begin : g_comb
         AST_REQ_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
            accept |-> cap_req);                                             // R2
      end
   endgenerate
endmodule

bind snap_ctl_reg snap_ctl_chk #(
   .DATA_W         (DATA_W),
   .BUSY_BIT       (BUSY_BIT),
   .NOCAP_BIT      (NOCAP_BIT),
   .REQ_REGISTERED (REQ_REGISTERED)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .rd_data  (rd_data),
   .cap_req  (cap_req),
   .cap_done (cap_done),
   .cap_ok   (cap_ok)
);

// File: tb/snap_ctl_reg_test.sv
module snap_ctl_reg_test;
   localparam int W = 64;
   localparam logic [W-1:0] ALL1  = {W{1'b1}};
   localparam logic [W-1:0] ONE0  = 64'h1;
   localparam logic [W-1:0] NOT0  = ~64'h1;

   typedef struct packed {
      logic         we;
      logic [W-1:0] wd;
      logic         dn;
      logic         ok;
      logic         e_busy;
      logic         e_nc;
      logic         e_req;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t TAB [NV] = '{
      '{1'b1, NOT0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 zero write while idle
      '{1'b1, ONE0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R2 start
      '{1'b0, '0,   1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 pulse ends, R7
      '{1'b1, ONE0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R5 write while busy
      '{1'b1, NOT0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R3 zero write while busy
      '{1'b0, '0,   1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 R8 captured
      '{1'b0, '0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // hold
      '{1'b0, '0,   1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 idle done ignored
      '{1'b1, ONE0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R7 nocap raised
      '{1'b0, '0,   1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R8 not captured
      '{1'b1, ALL1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R1 all-ones write
      '{1'b1, ONE0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 write+done collide
      '{1'b1, ONE0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R2 restart
      '{1'b0, '0,   1'b1, 1'b1, 1'b0, 1'b0, 1'b0}  // R4 completes
   };

   logic         clk = 1'b0;
   logic         rst_n;
   logic         wr_en;
   logic [W-1:0] wr_data;
   logic [W-1:0] rd_data;
   logic         cap_req;
   logic         cap_done;
   logic         cap_ok;
   int           checks = 0;
   int           fails  = 0;
   bit           done_run = 1'b0;

   always #4 clk = ~clk;

   snap_ctl_reg uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .rd_data  (rd_data),
      .cap_req  (cap_req),
      .cap_done (cap_done),
      .cap_ok   (cap_ok)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      wr_en = 1'b0; wr_data = '0; cap_done = 1'b0; cap_ok = 1'b0;
   endtask

   function automatic logic [W-1:0] reg_val(input logic b, input logic n);
      return (W'(n) << 32) | W'(b);
   endfunction

   initial begin
      #100000;
      if (!done_run) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      idle_inputs();
      repeat (3) @(negedge clk);
      chk("R9 reset value", rd_data, reg_val(1'b0, 1'b1));
      chk("R9 reset req", W'(cap_req), '0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         wr_en = TAB[i].we; wr_data = TAB[i].wd;
         cap_done = TAB[i].dn; cap_ok = TAB[i].ok;
         @(negedge clk);
         idle_inputs();
         chk("R1/R2/R4/R7/R8 vector reg", rd_data, reg_val(TAB[i].e_busy, TAB[i].e_nc));
         chk("R2/R5/R6 vector req", W'(cap_req), W'(TAB[i].e_req));
      end

      // R6: long capture, pulse must not repeat
      wr_en = 1'b1; wr_data = ONE0;
      @(negedge clk); idle_inputs();
      chk("R6 pulse start", W'(cap_req), 64'h1);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk("R6 no repeat", W'(cap_req), '0);
         chk("R7 held busy", rd_data, reg_val(1'b1, 1'b1));
      end
      cap_done = 1'b1; cap_ok = 1'b1;
      @(negedge clk); idle_inputs();
      chk("R4 long done", rd_data, reg_val(1'b0, 1'b0));

      // R9: reset mid-capture restores reset values
      wr_en = 1'b1; wr_data = ONE0;
      @(negedge clk); idle_inputs();
      rst_n = 1'b0;
      @(negedge clk);
      chk("R9 reset mid-capture", rd_data, reg_val(1'b0, 1'b1));
      chk("R9 reset mid-capture req", W'(cap_req), '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", rd_data, reg_val(1'b0, 1'b1));

      done_run = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule